// File: doc/BRIEF.md
# Programmable Sync and Blank Generator

This block turns a pair of externally supplied beam counters into four video timing pins: horizontal sync, vertical sync, composite sync and composite blank. Each sync signal is a set/reset flop whose set and clear events are equality matches between a counter and a programmed position. The counters, the display fetch and the register file that holds the positions all sit outside the block. The block only compares and shapes.

Vertical sync changes state only at one horizontal position on its start and stop lines. That position depends on the field type. On a short field it is the horizontal sync start. On a long field it is the line centre. This places the vertical edges half a line apart on alternate interlaced fields. During vertical sync, composite sync also fires at the line centre, which gives the doubled pulse rate of the equalising region. Every internal state bit is registered, so each pin follows the counter value that caused it one clock later. Polarity and pin routing are selected by static control inputs.

Top module: `sync_blank_gen`

## Requirements
- R1: Horizontal sync becomes active when `hcount` equals `hs_start` and inactive when `hcount` equals `hs_stop`. If both match in the same cycle, the start wins.
- R2: Vertical sync changes state only in a cycle where `hcount` equals the vertical edge position. In such a cycle it becomes active if `vcount` equals `vs_start`, otherwise it becomes inactive if `vcount` equals `vs_stop`, otherwise it holds.
- R3: The vertical edge position is `hs_start` on a short field and `hcenter` on a long field.
- R4: A field is long only when `interlace_en` is 1 and `field_odd` is 1. With `interlace_en` at 0, every field is short, whatever `field_odd` is.
- R5: Composite sync becomes active when `hcount` equals `hs_start`. It also becomes active when `hcount` equals `hcenter` while vertical sync is active.
- R6: Outside vertical sync, composite sync becomes inactive when `hcount` equals `hs_stop`. During vertical sync it becomes inactive instead when `hcount` equals `hb_start` or `hb_stop`. A set event wins over a clear event in the same cycle.
- R7: Composite blank is active when `hcount` lies in the half-open window [`hb_start`, `hb_stop`) or `vcount` lies in [`vb_start`, `vb_stop`). A window whose start is greater than its stop wraps through zero. A window whose start equals its stop is empty.
- R8: A polarity input of 1 drives the matching sync pin active-high, and 0 drives it active-low. `pol_hs` controls the horizontal sync, `pol_vs` the vertical sync and `pol_cs` the composite sync. `cblank_pin` is always active-high.
- R9: When `route_comp` is 1, `hsync_pin` carries the composite sync (with `pol_cs` polarity) and `vsync_pin` carries the composite blank (active-high). `var_hs_en` = 1 forces `hsync_pin` back to horizontal sync, and `var_vs_en` = 1 forces `vsync_pin` back to vertical sync. Each of these enables overrides the routing on its own pin.
- R10: All internal state is registered. Each pin reflects the counter values of the previous clock. After reset every sync and blank state is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcount | input | HW | Horizontal beam counter |
| vcount | input | VW | Vertical beam counter |
| interlace_en | input | 1 | Interlaced scan enable |
| field_odd | input | 1 | Field parity, 1 = long field when interlaced |
| hs_start | input | HW | Horizontal sync start position |
| hs_stop | input | HW | Horizontal sync stop position |
| hcenter | input | HW | Line centre position |
| hb_start | input | HW | Horizontal blank start |
| hb_stop | input | HW | Horizontal blank stop |
| vs_start | input | VW | Vertical sync start line |
| vs_stop | input | VW | Vertical sync stop line |
| vb_start | input | VW | Vertical blank start line |
| vb_stop | input | VW | Vertical blank stop line |
| pol_hs | input | 1 | Horizontal sync polarity, 1 = active-high |
| pol_vs | input | 1 | Vertical sync polarity, 1 = active-high |
| pol_cs | input | 1 | Composite sync polarity, 1 = active-high |
| route_comp | input | 1 | Route composite sync/blank to the h/v pins |
| var_hs_en | input | 1 | Keep horizontal sync on hsync_pin |
| var_vs_en | input | 1 | Keep vertical sync on vsync_pin |
| hsync_pin | output | 1 | Horizontal sync pin |
| vsync_pin | output | 1 | Vertical sync pin |
| csync_pin | output | 1 | Composite sync pin |
| cblank_pin | output | 1 | Composite blank pin |

## Verification
The assertions check the set and clear events of each sync flop on every cycle: horizontal sync after its start and stop matches, vertical sync holding between edge positions and setting at its start line, composite sync setting at the centre during vertical sync and clearing at the horizontal stop outside it, and the routed vertical pin matching the blank. The following behaviours show up only in the bench's scenarios, where a reference model follows whole frames:
- the choice of edge position from field parity and interlace
- the wrap of blank windows through zero
- the tie rules when positions coincide
- the polarity combinations

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int SPAN_W = 16;

  // Half-open window test with wrap-around; start == stop gives an empty window
  function automatic logic in_span(input logic [SPAN_W-1:0] x,
                                   input logic [SPAN_W-1:0] a,
                                   input logic [SPAN_W-1:0] b);
    if (a <= b) return (x >= a) && (x < b);
    return (x >= a) || (x < b);
  endfunction

  // Set/reset flop next state, set has priority
  function automatic logic sr_next(input logic cur, input logic set_hit,
                                   input logic clr_hit);
    if (set_hit) return 1'b1;
    if (clr_hit) return 1'b0;
    return cur;
  endfunction

  // Pin level for an active flag; active_high=0 inverts
  function automatic logic pin_level(input logic act, input logic active_high);
    return active_high ? act : ~act;
  endfunction
endpackage

// File: rtl/sbg_hv_sync.sv
module sbg_hv_sync #(
  parameter int HW = 9,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          long_field,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_stop,
  input  logic [HW-1:0] hcenter,
  input  logic [VW-1:0] vs_start,
  input  logic [VW-1:0] vs_stop,
  output logic          hs_q,
  output logic          vs_q
);
  import sbg_pkg::*;

  logic          hs_set_hit, hs_clr_hit;
  logic [HW-1:0] vedge_pos;
  logic          vedge_hit, vs_set_hit, vs_clr_hit;

  assign hs_set_hit = (hcount == hs_start);
  assign hs_clr_hit = (hcount == hs_stop);
  assign vedge_pos  = long_field ? hcenter : hs_start;
  assign vedge_hit  = (hcount == vedge_pos);
  assign vs_set_hit = vedge_hit && (vcount == vs_start);
  assign vs_clr_hit = vedge_hit && (vcount == vs_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= sr_next(hs_q, hs_set_hit, hs_clr_hit);
      vs_q <= sr_next(vs_q, vs_set_hit, vs_clr_hit);
    end
  end

  // R1
  hs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == hs_start) |=> hs_q);
  // R1
  hs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == hs_stop && hcount != hs_start) |=> !hs_q);
  // R2
  vs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vedge_hit |=> $stable(vs_q));
  // R2
  vs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vedge_hit && vcount == vs_start) |=> vs_q);
endmodule

// File: rtl/sbg_csync.sv
module sbg_csync #(
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic          vs_act,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_stop,
  input  logic [HW-1:0] hcenter,
  input  logic [HW-1:0] hb_start,
  input  logic [HW-1:0] hb_stop,
  output logic          cs_q
);
  import sbg_pkg::*;

  logic cs_set_hit, cs_clr_hit, ctr_pulse_hit;

  assign ctr_pulse_hit = vs_act && (hcount == hcenter);
  assign cs_set_hit    = (hcount == hs_start) || ctr_pulse_hit;
  assign cs_clr_hit    = vs_act ? ((hcount == hb_start) || (hcount == hb_stop))
                                : (hcount == hs_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b0;
    else        cs_q <= sr_next(cs_q, cs_set_hit, cs_clr_hit);
  end

  // R5
  cs_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_act && hcount == hcenter) |=> cs_q);
  // R6
  cs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_act && hcount == hs_stop && hcount != hs_start) |=> !cs_q);
endmodule

// File: rtl/sbg_blank.sv
module sbg_blank #(
  parameter int HW = 9,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic [HW-1:0] hb_start,
  input  logic [HW-1:0] hb_stop,
  input  logic [VW-1:0] vb_start,
  input  logic [VW-1:0] vb_stop,
  output logic          cb_q
);
  import sbg_pkg::*;

  localparam int HPAD = SPAN_W - HW;
  localparam int VPAD = SPAN_W - VW;

  logic h_in_blank, v_in_blank;

  assign h_in_blank = in_span({{HPAD{1'b0}}, hcount}, {{HPAD{1'b0}}, hb_start},
                              {{HPAD{1'b0}}, hb_stop});
  assign v_in_blank = in_span({{VPAD{1'b0}}, vcount}, {{VPAD{1'b0}}, vb_start},
                              {{VPAD{1'b0}}, vb_stop});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cb_q <= 1'b0;
    else        cb_q <= h_in_blank | v_in_blank;
  end

  // R7
  cb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_start == hb_stop && vb_start == vb_stop) |=> !cb_q);
endmodule

// File: rtl/sync_blank_gen.sv
module sync_blank_gen #(
  parameter int HW = 9,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          interlace_en,
  input  logic          field_odd,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_stop,
  input  logic [HW-1:0] hcenter,
  input  logic [HW-1:0] hb_start,
  input  logic [HW-1:0] hb_stop,
  input  logic [VW-1:0] vs_start,
  input  logic [VW-1:0] vs_stop,
  input  logic [VW-1:0] vb_start,
  input  logic [VW-1:0] vb_stop,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          pol_cs,
  input  logic          route_comp,
  input  logic          var_hs_en,
  input  logic          var_vs_en,
  output logic          hsync_pin,
  output logic          vsync_pin,
  output logic          csync_pin,
  output logic          cblank_pin
);
  import sbg_pkg::*;

  logic long_field;
  logic hs_q, vs_q, cs_q, cb_q;
  logic hs_lvl, vs_lvl, cs_lvl;

  assign long_field = interlace_en & field_odd;

  sbg_hv_sync #(.HW(HW), .VW(VW)) u_hv (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .long_field(long_field), .hs_start(hs_start), .hs_stop(hs_stop),
    .hcenter(hcenter), .vs_start(vs_start), .vs_stop(vs_stop),
    .hs_q(hs_q), .vs_q(vs_q));

  sbg_csync #(.HW(HW)) u_cs (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vs_act(vs_q),
    .hs_start(hs_start), .hs_stop(hs_stop), .hcenter(hcenter),
    .hb_start(hb_start), .hb_stop(hb_stop), .cs_q(cs_q));

  sbg_blank #(.HW(HW), .VW(VW)) u_bl (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .hb_start(hb_start), .hb_stop(hb_stop), .vb_start(vb_start),
    .vb_stop(vb_stop), .cb_q(cb_q));

  assign hs_lvl = pin_level(hs_q, pol_hs);
  assign vs_lvl = pin_level(vs_q, pol_vs);
  assign cs_lvl = pin_level(cs_q, pol_cs);

  assign hsync_pin  = (var_hs_en || !route_comp) ? hs_lvl : cs_lvl;
  assign vsync_pin  = (var_vs_en || !route_comp) ? vs_lvl : cb_q;
  assign csync_pin  = cs_lvl;
  assign cblank_pin = cb_q;

  // R9
  route_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_comp && !var_vs_en) |-> (vsync_pin == cblank_pin));
endmodule

// File: tb/sync_blank_gen_test.sv
module sync_blank_gen_test;
  localparam int HW = 9, VW = 9, HT = 32, VT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] hcount = '0, hs_start, hs_stop, hcenter, hb_start, hb_stop;
  logic [VW-1:0] vcount = '0, vs_start, vs_stop, vb_start, vb_stop;
  logic interlace_en = 0, field_odd = 0, pol_hs = 1, pol_vs = 1, pol_cs = 1;
  logic route_comp = 0, var_hs_en = 0, var_vs_en = 0;
  logic hsync_pin, vsync_pin, csync_pin, cblank_pin;

  int errors = 0, checks = 0;
  logic m_hs = 0, m_vs = 0, m_cs = 0, m_cb = 0;
  string vtag = "R2";

  always #2.5 clk = ~clk;

  sync_blank_gen #(.HW(HW), .VW(VW)) uut (.*);

  function automatic logic win(int x, int a, int b);
    if (a == b) return 1'b0;
    if (a < b) return x >= a && x < b;
    return x >= a || x < b;
  endfunction

  function automatic logic lvl(logic act, logic hi);
    return hi ? act : !act;
  endfunction

  // reference model, advanced on each clock from the requirement text
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hs = 0; m_vs = 0; m_cs = 0; m_cb = 0;
    end else begin
      int ep;
      logic vs_old, cs_set, cs_clr;
      vs_old = m_vs;
      ep = (interlace_en && field_odd) ? int'(hcenter) : int'(hs_start);
      cs_set = (hcount == hs_start) || (vs_old && hcount == hcenter);
      cs_clr = vs_old ? (hcount == hb_start || hcount == hb_stop) : (hcount == hs_stop);
      m_cb = win(hcount, hb_start, hb_stop) || win(vcount, vb_start, vb_stop);
      if (hcount == hs_start) m_hs = 1; else if (hcount == hs_stop) m_hs = 0;
      if (int'(hcount) == ep) begin
        if (vcount == vs_start) m_vs = 1; else if (vcount == vs_stop) m_vs = 0;
      end
      if (cs_set) m_cs = 1; else if (cs_clr) m_cs = 0;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (h=%0d v=%0d)", tag, act, exp, hcount, vcount);
    end
  endtask

  task automatic check_pins();
    logic eh, ev;
    eh = (var_hs_en || !route_comp) ? lvl(m_hs, pol_hs) : lvl(m_cs, pol_cs);
    ev = (var_vs_en || !route_comp) ? lvl(m_vs, pol_vs) : m_cb;
    chk(route_comp ? "R9 hsync" : "R1 R8 hsync", hsync_pin, eh);
    chk(route_comp ? "R9 vsync" : vtag, vsync_pin, ev);
    chk("R5 R6 R8 csync", csync_pin, lvl(m_cs, pol_cs));
    chk("R7 cblank", cblank_pin, m_cb);
  endtask

  task automatic run_frames(int n);
    for (int f = 0; f < n; f++) begin
      if (interlace_en) field_odd = ~field_odd;
      for (int v = 0; v < VT; v++)
        for (int h = 0; h < HT; h++) begin
          hcount = HW'(h); vcount = VW'(v);
          @(negedge clk);
          check_pins();
        end
    end
  endtask

  task automatic rand_regs();
    hs_start = HW'($urandom % HT); hs_stop = HW'($urandom % HT);
    hcenter  = HW'($urandom % HT); hb_start = HW'($urandom % HT);
    hb_stop  = HW'($urandom % HT);
    vs_start = VW'($urandom % VT); vs_stop = VW'($urandom % VT);
    vb_start = VW'($urandom % VT); vb_stop = VW'($urandom % VT);
    {pol_hs, pol_vs, pol_cs} = 3'($urandom);
    {route_comp, var_hs_en, var_vs_en, interlace_en} = 4'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    hs_start = 4; hs_stop = 8; hcenter = 20; hb_start = 2; hb_stop = 12;
    vs_start = 2; vs_stop = 4; vb_start = 0; vb_stop = 2;
    pol_hs = 0; pol_vs = 0; pol_cs = 0;
    repeat (3) @(negedge clk);
    // R10: reset state, all inactive -> low-active pins idle high
    chk("R10 hsync reset", hsync_pin, 1'b1);
    chk("R10 vsync reset", vsync_pin, 1'b1);
    chk("R10 csync reset", csync_pin, 1'b1);
    chk("R10 cblank reset", cblank_pin, 1'b0);
    rst_n = 1;
    // R10 latency: pin changes exactly one clock after the match
    hcount = 4; vcount = 5;
    chk("R10 before edge", hsync_pin, 1'b1);
    @(negedge clk);
    chk("R10 after edge", hsync_pin, 1'b0);
    // R3 R4: no interlace, odd parity still short
    vtag = "R3 R4 short vsync";
    interlace_en = 0; field_odd = 1;
    run_frames(2);
    // R3 R4: interlaced long/short alternation
    vtag = "R3 R4 interlaced vsync";
    interlace_en = 1;
    run_frames(4);
    // R7: wrapped blank windows, R1 tie start==stop
    vtag = "R2 vsync";
    hb_start = 28; hb_stop = 3; vb_start = 8; vb_stop = 1; hs_stop = hs_start;
    pol_hs = 1; pol_vs = 1; pol_cs = 1;
    run_frames(2);
    // R9: routing with and without per-pin override
    route_comp = 1; var_hs_en = 0; var_vs_en = 0; run_frames(1);
    var_hs_en = 1; var_vs_en = 1; run_frames(1);
    route_comp = 0;
    // random configurations
    for (int k = 0; k < 30; k++) begin
      rand_regs();
      vtag = interlace_en ? "R3 R4 rand vsync" : "R2 rand vsync";
      run_frames(2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule